// File: doc/BRIEF.md
# Potentiometer Serial Write Sequencer

This block is the master side of a three-wire serial link to a dual-channel digital potentiometer. It also drives the device's active-low reset pin. A 10-bit transmitter sends each write as a 2-bit channel address followed by an 8-bit wiper code. Bits go out most significant first. Each bit is placed on the data line before the serial clock rises, and the word is latched in the device when chip select returns high. All serial timing runs on a divided tick, and the division ratio is a parameter.

A fixed script runs on top of the transmitter, with no host interface. It first sets channel 1 to quarter scale and then pulses the device reset. Next it sets channel 2 to code 51. After that it writes an incrementing ramp to channel 1 forever. The block is meant for bring-up and self-test of the analog path: the ramp produces a repeating sawtooth on the channel 1 wiper.

Two state machines do the work. The transmitter machine has these states: TX_IDLE (bus quiet, divider held clear), TX_SETUP (chip select low, bit on the data line, clock low), TX_RISE (clock high), TX_HOLD (clock low, bit held) and TX_GAP (chip select high for the inter-write gap). Its transitions are:
- TX_IDLE to TX_SETUP on a start request.
- TX_SETUP to TX_RISE, then TX_RISE to TX_HOLD, each on a tick.
- TX_HOLD to TX_SETUP on a tick while bits remain.
- TX_HOLD to TX_GAP on a tick after the tenth bit.
- TX_GAP to TX_IDLE after two ticks, which also flags completion.

The script machine has these states: SQ_Q_SEND and SQ_Q_WAIT (quarter-scale write), SQ_RST (device reset low), SQ_C2_SEND and SQ_C2_WAIT (channel 2 write), and SQ_RAMP_SEND and SQ_RAMP_WAIT (ramp writes). Each SEND state issues one start request and moves to its WAIT state. Each WAIT state advances on completion. SQ_RST leaves after its programmed length. SQ_RAMP_WAIT returns to SQ_RAMP_SEND and bumps the ramp counter.

Top module: `pot_write_seq`

## Requirements
- R1: While system reset is asserted the outputs are: serial clock 0, serial data 0, chip select 1, device reset 1, busy 0.
- R2: Every write drives chip select low, produces exactly 10 rising edges of the serial clock, and then returns chip select high.
- R3: Bits are sent as address bit 1, address bit 0, then code bits 7 down to 0, and are valid at the serial clock rising edge. The word is therefore {addr[1:0], code[7:0]}.
- R4: Serial data changes only while the serial clock is low. It is stable for at least DIV system clocks before each clock rise and for at least DIV system clocks after each clock fall.
- R5: The first write after reset carries address 0 (channel 1) and code 0x40.
- R6: After the first write completes, device reset goes low for exactly RST_LEN system clocks (default 4) while chip select stays high, and then returns high.
- R7: The second write carries address 1 (channel 2) and code 51 (word 0x133).
- R8: Every later write carries address 0 and codes 0, 1, 2, and so on, incrementing by one per write and wrapping from 255 to 0.
- R9: Between consecutive writes chip select stays high for at least 2*DIV system clocks.
- R10: Busy is high exactly while chip select is low.
- R11: The serial clock is high only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| pot_sclk | output | 1 | Serial clock to the potentiometer; the device samples on its rising edge |
| pot_sdi | output | 1 | Serial data to the potentiometer |
| pot_cs_n | output | 1 | Active-low chip select; its rising edge latches the word |
| dev_rst_n | output | 1 | Active-low device reset; a low pulse returns the wipers to midscale |
| busy | output | 1 | High while a write frame is on the bus |

## Verification
A wrong transmitter state shows up at the ports within one frame. A bit counter that slips gives a frame with 9 or 11 clock rises. A wrong shift order shows up as a wrong word, already in the first write (0x040) or in the second (0x133). A tick or state that is out of step shows up as data changing inside the setup or hold window, or as a chip-select gap shorter than two ticks. In the script machine, a wrong state order moves the reset pulse to the wrong frame or changes its length. A faulty ramp counter appears in the first ramp frame, or at the 256th ramp frame, where the code must wrap back to 0.

// File: rtl/pot_seq_pkg.sv
package pot_seq_pkg;

    localparam int ADDR_W = 2;
    localparam int CODE_W = 8;
    localparam int WORD_W = ADDR_W + CODE_W;

    localparam logic [ADDR_W-1:0] CH1_ADDR = 2'd0;
    localparam logic [ADDR_W-1:0] CH2_ADDR = 2'd1;
    localparam logic [CODE_W-1:0] QUARTER_CODE = 8'h40;
    localparam logic [CODE_W-1:0] CH2_CODE = 8'd51;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_RISE,
        TX_HOLD,
        TX_GAP
    } tx_state_t;

    typedef enum logic [2:0] {
        SQ_Q_SEND,
        SQ_Q_WAIT,
        SQ_RST,
        SQ_C2_SEND,
        SQ_C2_WAIT,
        SQ_RAMP_SEND,
        SQ_RAMP_WAIT
    } seq_state_t;

endpackage

// File: rtl/pot_tick_gen.sv
module pot_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = !clr && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/pot_frame_tx.sv
module pot_frame_tx
    import pot_seq_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int GAP_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              sclk,
    output logic              sdi,
    output logic              cs_n,
    output logic              busy,
    output logic              done
);
    localparam int BW = $clog2(WORD_W);
    localparam int GW = $clog2(GAP_TICKS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);
    localparam logic [GW-1:0] LAST_GAP = GW'(GAP_TICKS - 1);

    tx_state_t         state, state_nx;
    logic [WORD_W-1:0] shreg;
    logic [BW-1:0]     bit_idx;
    logic [GW-1:0]     gap_cnt;
    logic              tick;

    pot_tick_gen #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state == TX_IDLE),
        .tick (tick)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (start) state_nx = TX_SETUP;
            TX_SETUP: if (tick) state_nx = TX_RISE;
            TX_RISE:  if (tick) state_nx = TX_HOLD;
            TX_HOLD:  if (tick) state_nx = (bit_idx == LAST_BIT) ? TX_GAP : TX_SETUP;
            TX_GAP:   if (tick && gap_cnt == LAST_GAP) state_nx = TX_IDLE;
            default:  state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            gap_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == TX_IDLE && start) begin
                shreg   <= word;
                bit_idx <= '0;
                gap_cnt <= '0;
            end
            if (state == TX_HOLD && tick && bit_idx != LAST_BIT) begin
                shreg   <= {shreg[WORD_W-2:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == TX_GAP && tick) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        busy = (state == TX_SETUP) || (state == TX_RISE) || (state == TX_HOLD);
        cs_n = !busy;
        sclk = (state == TX_RISE);
        sdi  = busy && shreg[WORD_W-1];
        done = (state == TX_GAP) && tick && (gap_cnt == LAST_GAP);
    end

    p_sclk_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);
    p_sdi_steady_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdi));
    p_ten_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ($past(bit_idx) == LAST_BIT));
    p_busy_tracks_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy != cs_n);

endmodule

// File: rtl/pot_write_seq.sv
module pot_write_seq
    import pot_seq_pkg::*;
#(
    parameter int DIV     = 4,
    parameter int RST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic pot_sclk,
    output logic pot_sdi,
    output logic pot_cs_n,
    output logic dev_rst_n,
    output logic busy
);
    localparam int RW = $clog2(RST_LEN + 1) + 1;
    localparam logic [RW-1:0] RST_LAST = RW'(RST_LEN - 1);

    seq_state_t        state, state_nx;
    logic [CODE_W-1:0] ramp;
    logic [RW-1:0]     rcnt;
    logic              tx_start;
    logic [WORD_W-1:0] tx_word;
    logic              tx_done;

    pot_frame_tx #(.DIV(DIV), .GAP_TICKS(2)) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .start(tx_start),
        .word (tx_word),
        .sclk (pot_sclk),
        .sdi  (pot_sdi),
        .cs_n (pot_cs_n),
        .busy (busy),
        .done (tx_done)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_Q_SEND:    state_nx = SQ_Q_WAIT;
            SQ_Q_WAIT:    if (tx_done) state_nx = SQ_RST;
            SQ_RST:       if (rcnt == RST_LAST) state_nx = SQ_C2_SEND;
            SQ_C2_SEND:   state_nx = SQ_C2_WAIT;
            SQ_C2_WAIT:   if (tx_done) state_nx = SQ_RAMP_SEND;
            SQ_RAMP_SEND: state_nx = SQ_RAMP_WAIT;
            SQ_RAMP_WAIT: if (tx_done) state_nx = SQ_RAMP_SEND;
            default:      state_nx = SQ_Q_SEND;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_Q_SEND;
            ramp  <= '0;
            rcnt  <= '0;
        end else begin
            state <= state_nx;
            rcnt  <= (state == SQ_RST) ? rcnt + 1'b1 : '0;
            if (state == SQ_RAMP_WAIT && tx_done) begin
                ramp <= ramp + 1'b1;
            end
        end
    end

    always_comb begin
        tx_start  = 1'b0;
        tx_word   = '0;
        dev_rst_n = 1'b1;
        unique case (state)
            SQ_Q_SEND: begin
                tx_start = 1'b1;
                tx_word  = {CH1_ADDR, QUARTER_CODE};
            end
            SQ_C2_SEND: begin
                tx_start = 1'b1;
                tx_word  = {CH2_ADDR, CH2_CODE};
            end
            SQ_RAMP_SEND: begin
                tx_start = 1'b1;
                tx_word  = {CH1_ADDR, ramp};
            end
            SQ_RST:  dev_rst_n = 1'b0;
            default: ;
        endcase
    end

    logic [RW-1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst_n) low_run <= '0;
        else                     low_run <= low_run + 1'b1;
    end

    p_rst_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n) |-> (low_run == RW'(RST_LEN)));
    p_rst_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_rst_n |-> pot_cs_n);
    p_ramp_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RAMP_WAIT && tx_done) |=> (ramp == CODE_W'($past(ramp) + 1'b1)));
    p_start_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> pot_cs_n);

endmodule

// File: tb/tb_pot_write_seq.sv
`timescale 1ns/1ps
module tb_pot_write_seq;
    localparam int DIV     = 4;
    localparam int RST_LEN = 4;
    localparam int NFR     = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pot_sclk, pot_sdi, pot_cs_n, dev_rst_n, busy;

    always #2 clk = ~clk;

    pot_write_seq #(.DIV(DIV), .RST_LEN(RST_LEN)) dut (
        .clk(clk), .rst_n(rst_n), .pot_sclk(pot_sclk), .pot_sdi(pot_sdi),
        .pot_cs_n(pot_cs_n), .dev_rst_n(dev_rst_n), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [9:0] fw [0:NFR-1];
    int fbits [0:NFR-1];
    int frame_cnt = 0;
    logic [9:0] cur_word;
    int cur_bits;
    int p_cs = 1, p_sclk = 0, p_sdi = 0, p_rst = 1;
    int since_fall = 1000, sdi_age = 1000, hi_run = 0, min_gap = 1000;
    int rlow = 0, rst_len = 0, rst_cnt = 0, rst_after = -1, rst_cs_viol = 0;
    int sdi_viol = 0, setup_viol = 0, busy_viol = 0, sclk_viol = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!pot_cs_n && pot_sclk && p_sclk == 0) begin
                if (sdi_age < DIV) setup_viol++;
                cur_word = {cur_word[8:0], pot_sdi};
                cur_bits++;
            end
            if (int'(pot_sdi) != p_sdi) begin
                if (!pot_cs_n && (pot_sclk || p_sclk == 1 || since_fall < DIV)) sdi_viol++;
                sdi_age = 1;
            end else if (sdi_age < 1000) sdi_age++;
            if (pot_sclk) since_fall = 0;
            else if (since_fall < 1000) since_fall++;
            if (p_cs == 1 && !pot_cs_n) begin
                if (frame_cnt > 0 && hi_run < min_gap) min_gap = hi_run;
                cur_word = '0;
                cur_bits = 0;
            end
            if (p_cs == 0 && pot_cs_n) begin
                if (frame_cnt < NFR) begin
                    fw[frame_cnt] = cur_word;
                    fbits[frame_cnt] = cur_bits;
                end
                frame_cnt++;
            end
            if (pot_cs_n) hi_run++; else hi_run = 0;
            if (!dev_rst_n) begin
                rlow++;
                if (!pot_cs_n) rst_cs_viol++;
            end
            if (dev_rst_n && p_rst == 0) begin
                rst_len = rlow;
                rlow = 0;
                rst_cnt++;
                rst_after = frame_cnt;
            end
            if (busy == pot_cs_n) busy_viol++;
            if (pot_sclk && pot_cs_n) sclk_viol++;
            p_cs = int'(pot_cs_n);
            p_sclk = int'(pot_sclk);
            p_sdi = int'(pot_sdi);
            p_rst = int'(dev_rst_n);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        while (frame_cnt < n) @(negedge clk);
    endtask

    // R1: outputs while reset is held
    task automatic t_reset_state();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(pot_sclk == 1'b0, "R1 sclk", int'(pot_sclk), 0);
        check(pot_sdi == 1'b0, "R1 sdi", int'(pot_sdi), 0);
        check(pot_cs_n == 1'b1, "R1 cs_n", int'(pot_cs_n), 1);
        check(dev_rst_n == 1'b1, "R1 dev_rst_n", int'(dev_rst_n), 1);
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        rst_n = 1'b1;
    endtask

    // R5, R2, R3: first write is channel 1 quarter scale
    task automatic t_first_write();
        wait_frames(1);
        check(fbits[0] == 10, "R2 first frame bits", fbits[0], 10);
        check(fw[0] == 10'h040, "R5 first word", int'(fw[0]), 'h040);
    endtask

    // R6: device reset pulse
    task automatic t_dev_reset();
        while (rst_cnt < 1) @(negedge clk);
        check(rst_len == RST_LEN, "R6 pulse length", rst_len, RST_LEN);
        check(rst_after == 1, "R6 after first frame", rst_after, 1);
        check(rst_cs_viol == 0, "R6 cs during reset", rst_cs_viol, 0);
    endtask

    // R7, R3: channel 2 write, address bits lead
    task automatic t_second_write();
        wait_frames(2);
        check(fw[1] == 10'h133, "R7 second word", int'(fw[1]), 'h133);
        check(fw[1][9:8] == 2'b01, "R3 address bits first", int'(fw[1][9:8]), 1);
    endtask

    // R8: ramp on channel 1 including the wrap
    task automatic t_ramp();
        wait_frames(262);
        for (int k = 0; k < 260; k++) begin
            check(fw[2 + k] == {2'b00, 8'(k)}, "R8 ramp word", int'(fw[2 + k]), k % 256);
        end
        check(fw[258] == 10'h000, "R8 wrap to zero", int'(fw[258]), 0);
        check(fw[257] == 10'h0FF, "R8 full scale before wrap", int'(fw[257]), 'h0FF);
        check(rst_cnt == 1, "R6 single reset pulse", rst_cnt, 1);
    endtask

    // R2, R4, R9, R10, R11: bus timing over every frame seen
    task automatic t_timing();
        int badbits = 0;
        for (int i = 0; i < 262; i++) if (fbits[i] != 10) badbits++;
        check(badbits == 0, "R2 frames with wrong bit count", badbits, 0);
        check(sdi_viol == 0, "R4 data hold violations", sdi_viol, 0);
        check(setup_viol == 0, "R4 data setup violations", setup_viol, 0);
        check(min_gap >= 2 * DIV, "R9 min chip select gap", min_gap, 2 * DIV);
        check(busy_viol == 0, "R10 busy mismatch", busy_viol, 0);
        check(sclk_viol == 0, "R11 clock outside frame", sclk_viol, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", frame_cnt, 262);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_first_write();
        t_dev_reset();
        t_second_write();
        t_ramp();
        t_timing();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule